// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block connects a synchronous host request port to an extended-data-out DRAM with 512 rows, 512 columns and 16-bit words. The host issues one read or one write at a time through a valid/ready handshake. Each request carries an 18-bit word address, write data and two byte enables. Reads complete with a one-cycle response strobe and the returned word.

The controller multiplexes the row and column halves of the address onto nine shared pins. It drives the row strobe, separate lower and upper column strobes, write enable and output enable. Every strobe comes straight from a flip-flop.

After an access the row stays open. A later request to the same row is served by pulsing the column strobes only. A request to another row closes the row, waits out the precharge time, and then activates the new row. A free-running interval timer requests a CAS-before-RAS refresh cycle about every 15.6 µs. Every analogue timing limit is a nanosecond parameter, rounded up to whole clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, all active-low strobes (`ras_n`, `cas_lo_n`, `cas_hi_n`, `we_n`, `oe_n`) are high. In the same window `rsp_valid` is 0 and `req_ready` is 1.
- R2: Host address bits [17:9] appear on `dram_addr` when `ras_n` falls. Bits [8:0] appear when the column strobes fall.
- R3: Byte enable bit 0 drives `cas_lo_n`, which covers data bits 7:0. Byte enable bit 1 drives `cas_hi_n`, which covers bits 15:8. A byte whose enable is 0 keeps its stored value.
- R4: A read samples `dq_in` C cycles after the column strobe falls, where C = max(ceil(tCAC), ceil(tRAC) − RCD − 1). The read returns that word with `rsp_valid` high for one cycle, on the same edge.
- R5: On a write, `we_n` is already low one cycle before any column strobe falls, and `oe_n` stays high. On a read, `oe_n` is low when the column strobe falls.
- R6: While a row is open, a request to the same row triggers no new row activation.
- R7: Between a rising edge and the next falling edge of `ras_n`, at least ceil(tRP) cycles pass.
- R8: Every low pulse of `ras_n` lasts at least max(ceil(tRAS), ceil(tRC) − ceil(tRP)) cycles.
- R9: Refresh lowers both column strobes while `ras_n` is high and holds them for at least ceil(tCSR) cycles. Then `ras_n` falls, and the column strobes stay low for at least ceil(tCHR) more cycles. Successive refreshes start no more than ceil(tREFI) cycles apart, plus the length of one access.
- R10: A due refresh comes before new host requests, and `req_ready` is low during the refresh cycle.
- R11: A row never stays open longer than ceil(tRASMAX) cycles.
- R12: Between two page-mode column pulses, the column strobes stay high for at least ceil(tCP) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in [17:9], column in [8:0] |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 for the low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| dram_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Low-byte column strobe, active low |
| cas_hi_n | output | 1 | High-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | 16 | Data toward the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 16 | Data from the memory |

## Verification
The bench runs four kinds of traffic, and each one isolates a different behaviour.
- Runs of accesses that stay in one row separate page hits from needless reactivations.
- Alternating rows and extreme row/column values expose any swap in the address multiplexing or any skipped precharge.
- Partial-byte writes followed by full-word reads reveal whether the lower and upper strobes are swapped or merged.
- Long idle gaps and long same-row streams test whether refresh preempts an open page, and whether the row-open limit holds.

A randomised mix of reads and writes over a small address pool is compared against a shadow memory. It also drives every strobe-timing rule across many different interleavings of refresh and host traffic.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ASR, ST_RCD, ST_CSET, ST_CAS, ST_CP, ST_OPEN,
    ST_CLOSE, ST_PRE, ST_RCSR, ST_RCHR, ST_RTAIL
  } edo_state_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_wait_timer.sv
module edo_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/edo_refresh_tick.sv
module edo_refresh_tick #(
  parameter int INTERVAL = 1954
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)      pend <= 1'b1;
      else if (done) pend <= 1'b0;
    end
  end

  // R9
  ref_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !pend);
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int ROW_W   = 9,
  parameter int MIN_CYC = 5,
  parameter int MAX_CYC = 1250,
  parameter int LIM_CYC = 1243
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_evt,
  input  logic             close_evt,
  input  logic [ROW_W-1:0] open_row,
  input  logic [ROW_W-1:0] req_row,
  output logic             hit,
  output logic             min_ok,
  output logic             near_max
);
  localparam int CW = $clog2(MAX_CYC + 2);
  logic             is_open;
  logic [ROW_W-1:0] row_q;
  logic [CW-1:0]    low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
      low_cnt <= '0;
    end else if (open_evt) begin
      is_open <= 1'b1;
      row_q   <= open_row;
      low_cnt <= CW'(1);
    end else if (close_evt) begin
      is_open <= 1'b0;
    end else if (is_open && low_cnt != CW'(MAX_CYC + 1)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign hit      = is_open && (req_row == row_q);
  assign min_ok   = low_cnt >= CW'(MIN_CYC);
  assign near_max = low_cnt >= CW'(LIM_CYC);

  // R8
  ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |-> (is_open && low_cnt >= CW'(MIN_CYC)));
  // R11
  ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_open |-> (low_cnt <= CW'(MAX_CYC)));
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int MUX_W       = 9,
  parameter int DATA_W      = 16,
  parameter int CLK_PS      = 8000,
  parameter int T_RP_NS     = 25,
  parameter int T_RAS_NS    = 35,
  parameter int T_RC_NS     = 65,
  parameter int T_RCD_NS    = 15,
  parameter int T_RAC_NS    = 35,
  parameter int T_CAC_NS    = 10,
  parameter int T_CP_NS     = 10,
  parameter int T_CSR_NS    = 10,
  parameter int T_CHR_NS    = 10,
  parameter int T_REFI_NS   = 15625,
  parameter int T_RASMAX_NS = 10000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [2*MUX_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [1:0]          req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [MUX_W-1:0]    dram_addr,
  output logic                ras_n,
  output logic                cas_lo_n,
  output logic                cas_hi_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  input  logic [DATA_W-1:0]   dq_in
);
  localparam int RP_C   = ns2cyc(T_RP_NS, CLK_PS);
  localparam int RCD_C  = imax(1, ns2cyc(T_RCD_NS, CLK_PS));
  localparam int RMIN_C = imax(ns2cyc(T_RAS_NS, CLK_PS), ns2cyc(T_RC_NS, CLK_PS) - RP_C);
  localparam int CAC_C  = imax(ns2cyc(T_CAC_NS, CLK_PS), ns2cyc(T_RAC_NS, CLK_PS) - RCD_C - 1);
  localparam int CP_C   = imax(1, ns2cyc(T_CP_NS, CLK_PS));
  localparam int CSR_C  = imax(1, ns2cyc(T_CSR_NS, CLK_PS));
  localparam int CHR_C  = imax(1, ns2cyc(T_CHR_NS, CLK_PS));
  localparam int TAIL_C = imax(1, RMIN_C - CHR_C);
  localparam int REFI_C = ns2cyc(T_REFI_NS, CLK_PS);
  localparam int RMAX_C = ns2cyc(T_RASMAX_NS, CLK_PS);
  localparam int LIM_C  = RMAX_C - (CAC_C + CP_C + 3);
  localparam int TW     = 8;

  edo_state_e st, st_d;

  // latched command
  logic               have_cmd, c_we;
  logic [MUX_W-1:0]   c_row, c_col;
  logic [DATA_W-1:0]  c_wdata;
  logic [1:0]         c_be;

  // named internal events
  logic               ref_pend, ref_done, trk_open, trk_close;
  logic               hit, min_ok, near_max, tmr_zero, tmr_ld;
  logic [TW-1:0]      tmr_val;
  logic               req_fire, take, cap, cmd_clr;
  logic [MUX_W-1:0]   req_row, req_col;

  // next values of the registered pins
  logic               ras_d, casl_d, cash_d, we_d, oe_d, dqoe_d;
  logic [MUX_W-1:0]   addr_d;
  logic [DATA_W-1:0]  dqo_d;

  assign req_row = req_addr[2*MUX_W-1:MUX_W];
  assign req_col = req_addr[MUX_W-1:0];

  assign req_ready = (st == ST_IDLE && !ref_pend && !have_cmd) ||
                     (st == ST_OPEN && !ref_pend && !near_max);
  assign req_fire  = req_valid && req_ready;

  edo_refresh_tick #(.INTERVAL(REFI_C)) u_ref (
    .clk(clk), .rst_n(rst_n), .done(ref_done), .pend(ref_pend));

  edo_wait_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero));

  edo_row_tracker #(.ROW_W(MUX_W), .MIN_CYC(RMIN_C), .MAX_CYC(RMAX_C), .LIM_CYC(LIM_C)) u_trk (
    .clk(clk), .rst_n(rst_n), .open_evt(trk_open), .close_evt(trk_close),
    .open_row(c_row), .req_row(req_row), .hit(hit), .min_ok(min_ok), .near_max(near_max));

  always_comb begin
    st_d = st;   tmr_ld = 1'b0;  tmr_val = '0;
    ras_d = ras_n; casl_d = cas_lo_n; cash_d = cas_hi_n;
    we_d = we_n; oe_d = oe_n; dqoe_d = dq_oe; addr_d = dram_addr; dqo_d = dq_out;
    take = 1'b0; cap = 1'b0; cmd_clr = 1'b0;
    ref_done = 1'b0; trk_open = 1'b0; trk_close = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (ref_pend) begin
          casl_d = 1'b0; cash_d = 1'b0;
          tmr_ld = 1'b1; tmr_val = TW'(CSR_C - 1); st_d = ST_RCSR;
        end else if (have_cmd) begin
          addr_d = c_row; st_d = ST_ASR;
        end else if (req_fire) begin
          take = 1'b1; addr_d = req_row; st_d = ST_ASR;
        end
      end
      ST_ASR: begin
        ras_d = 1'b0; trk_open = 1'b1;
        tmr_ld = 1'b1; tmr_val = TW'(RCD_C - 1); st_d = ST_RCD;
      end
      ST_RCD: if (tmr_zero) begin
        addr_d = c_col; we_d = !c_we; oe_d = c_we; dqo_d = c_wdata; dqoe_d = c_we;
        st_d = ST_CSET;
      end
      ST_CSET: begin
        casl_d = !c_be[0]; cash_d = !c_be[1];
        tmr_ld = 1'b1; tmr_val = TW'(CAC_C - 1); st_d = ST_CAS;
      end
      ST_CAS: if (tmr_zero) begin
        cap = !c_we; cmd_clr = 1'b1;
        casl_d = 1'b1; cash_d = 1'b1; we_d = 1'b1; oe_d = 1'b1; dqoe_d = 1'b0;
        tmr_ld = 1'b1; tmr_val = TW'(CP_C - 1); st_d = ST_CP;
      end
      ST_CP: if (tmr_zero) st_d = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend || near_max) begin
          st_d = ST_CLOSE;
        end else if (req_fire) begin
          take = 1'b1;
          if (hit) begin
            addr_d = req_col; we_d = !req_we; oe_d = req_we;
            dqo_d = req_wdata; dqoe_d = req_we; st_d = ST_CSET;
          end else begin
            st_d = ST_CLOSE;
          end
        end
      end
      ST_CLOSE: if (min_ok) begin
        ras_d = 1'b1; trk_close = 1'b1;
        tmr_ld = 1'b1; tmr_val = TW'(RP_C - 1); st_d = ST_PRE;
      end
      ST_PRE: if (tmr_zero) st_d = ST_IDLE;
      ST_RCSR: if (tmr_zero) begin
        ras_d = 1'b0; tmr_ld = 1'b1; tmr_val = TW'(CHR_C - 1); st_d = ST_RCHR;
      end
      ST_RCHR: if (tmr_zero) begin
        casl_d = 1'b1; cash_d = 1'b1;
        tmr_ld = 1'b1; tmr_val = TW'(TAIL_C - 1); st_d = ST_RTAIL;
      end
      ST_RTAIL: if (tmr_zero) begin
        ras_d = 1'b1; ref_done = 1'b1;
        tmr_ld = 1'b1; tmr_val = TW'(RP_C - 1); st_d = ST_PRE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; have_cmd <= 1'b0; c_we <= 1'b0;
      c_row <= '0; c_col <= '0; c_wdata <= '0; c_be <= '0;
      ras_n <= 1'b1; cas_lo_n <= 1'b1; cas_hi_n <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1;
      dq_oe <= 1'b0; dq_out <= '0; dram_addr <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      st <= st_d;
      ras_n <= ras_d; cas_lo_n <= casl_d; cas_hi_n <= cash_d;
      we_n <= we_d; oe_n <= oe_d; dq_oe <= dqoe_d; dq_out <= dqo_d; dram_addr <= addr_d;
      if (take) begin
        have_cmd <= 1'b1; c_we <= req_we; c_row <= req_row; c_col <= req_col;
        c_wdata <= req_wdata; c_be <= req_be;
      end else if (cmd_clr) begin
        have_cmd <= 1'b0;
      end
      rsp_valid <= cap;
      if (cap) rsp_rdata <= dq_in;
    end
  end

  // R9
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_lo_n) |-> ($past(!cas_lo_n) && $past(!cas_hi_n)));
  // R5
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(cas_lo_n) || $fell(cas_hi_n)) && !we_n) |-> ($past(!we_n) && oe_n));
  // R6
  page_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CSET) |-> !ras_n);
  // R10
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && st == ST_IDLE) |=> (st == ST_RCSR && !cas_lo_n));
endmodule

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
  localparam int PER_PS = 8000;

  function automatic int cyc_of(input int ns);
    int c;
    c = ns * 1000 / PER_PS;
    if (c * PER_PS < ns * 1000) c = c + 1;
    return c;
  endfunction
  function automatic int bigger(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  localparam int E_RP   = cyc_of(25);
  localparam int E_RCD  = cyc_of(15);
  localparam int E_RMIN = bigger(cyc_of(35), cyc_of(65) - E_RP);
  localparam int E_CAC  = bigger(cyc_of(10), cyc_of(35) - E_RCD - 1);
  localparam int E_CP   = cyc_of(10);
  localparam int E_CSR  = cyc_of(10);
  localparam int E_CHR  = cyc_of(10);
  localparam int E_REFI = cyc_of(15625);
  localparam int E_RMAX = cyc_of(10000);
  localparam int SLACK  = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_ready;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic rsp_valid; logic [15:0] rsp_rdata;
  logic [8:0] dram_addr;
  logic ras_n, cas_lo_n, cas_hi_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_out;
  logic [15:0] dq_model = '0;

  edo_dram_ctrl u_edo_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_model));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // DRAM model and strobe monitor
  logic [7:0] m_lo [int];
  logic [7:0] m_hi [int];
  logic [7:0] s_lo [int];
  logic [7:0] s_hi [int];
  logic [8:0] row_l = '0, col_l = '0;
  logic p_ras = 1'b1, p_cl = 1'b1, p_ch = 1'b1, p_we = 1'b1;
  int t_fall = 0, t_rise = 0, t_cbr = 0, t_ref = 0, t_casf = 0, t_casr = 0;
  bit have_rise = 0, in_cbr = 0, have_casr = 0;
  int n_ref = 0, n_act = 0;

  always @(negedge clk) begin
    int k;
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (!cas_lo_n && !cas_hi_n) begin
          chk(cyc - t_cbr >= E_CSR, "R9 CAS setup before RAS", cyc - t_cbr, E_CSR);
          if (n_ref > 0)
            chk(cyc - t_ref <= E_REFI + SLACK, "R9 refresh spacing", cyc - t_ref, E_REFI);
          t_ref = cyc; n_ref++; in_cbr = 1;
        end else begin
          row_l = dram_addr; n_act++;
        end
        if (have_rise) chk(cyc - t_rise >= E_RP, "R7 RAS precharge", cyc - t_rise, E_RP);
        t_fall = cyc; have_casr = 0;
      end
      if (!p_ras && ras_n) begin
        chk(cyc - t_fall >= E_RMIN, "R8 RAS low minimum", cyc - t_fall, E_RMIN);
        chk(cyc - t_fall <= E_RMAX, "R11 RAS low maximum", cyc - t_fall, E_RMAX);
        t_rise = cyc; have_rise = 1; in_cbr = 0;
      end
      if (p_cl && p_ch && (!cas_lo_n || !cas_hi_n)) begin
        if (ras_n) begin
          t_cbr = cyc;
          chk(!cas_lo_n && !cas_hi_n, "R9 both CAS in refresh", {cas_hi_n, cas_lo_n}, 0);
          chk(!req_ready, "R10 ready low in refresh", req_ready, 0);
        end else begin
          if (have_casr) chk(cyc - t_casr >= E_CP, "R12 CAS precharge", cyc - t_casr, E_CP);
          col_l = dram_addr; t_casf = cyc;
          k = {row_l, col_l};
          if (!we_n) begin
            chk(!p_we && oe_n, "R5 early write, OE high", {p_we, oe_n}, 1);
            if (!cas_lo_n) m_lo[k] = dq_out[7:0];
            if (!cas_hi_n) m_hi[k] = dq_out[15:8];
          end else begin
            chk(!oe_n, "R5 OE low on read", oe_n, 0);
          end
        end
      end
      if (!(p_cl && p_ch) && cas_lo_n && cas_hi_n && !ras_n) begin
        if (in_cbr) chk(cyc - t_fall >= E_CHR, "R9 CAS hold after RAS", cyc - t_fall, E_CHR);
        t_casr = cyc; have_casr = 1;
      end
      if (rsp_valid) chk(cyc - t_casf == E_CAC, "R4 read sample delay", cyc - t_casf, E_CAC);
      k = {row_l, col_l};
      dq_model[7:0]  = (!oe_n && !cas_lo_n && m_lo.exists(k)) ? m_lo[k] : 8'h00;
      dq_model[15:8] = (!oe_n && !cas_hi_n && m_hi.exists(k)) ? m_hi[k] : 8'h00;
    end
    p_ras = ras_n; p_cl = cas_lo_n; p_ch = cas_hi_n; p_we = we_n;
  end

  task automatic issue(input bit we, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1'b1, a, d, be);
    if (be[0]) s_lo[int'(a)] = d[7:0];
    if (be[1]) s_hi[int'(a)] = d[15:8];
  endtask

  task automatic rd(input logic [17:0] a, input logic [1:0] be, input string tag);
    logic [15:0] exp, msk;
    issue(1'b0, a, 16'h0, be);
    while (!rsp_valid) @(negedge clk);
    exp[7:0]  = s_lo.exists(int'(a)) ? s_lo[int'(a)] : 8'h00;
    exp[15:8] = s_hi.exists(int'(a)) ? s_hi[int'(a)] : 8'h00;
    msk = {{8{be[1]}}, {8{be[0]}}};
    chk((rsp_rdata & msk) == (exp & msk), tag, int'(rsp_rdata & msk), int'(exp & msk));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc >= 190000);
    chk(1'b0, "R1 watchdog", cyc, 190000);
    summary();
  end

  initial begin
    int a0;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk(ras_n && cas_lo_n && cas_hi_n && we_n && oe_n, "R1 strobes idle in reset",
        {ras_n, cas_lo_n, cas_hi_n, we_n, oe_n}, 31);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 ready after reset", {rsp_valid, req_ready}, 1);

    // R6: page hits in one row
    a0 = n_act;
    for (int i = 0; i < 4; i++) wr({9'd3, 9'(i)}, 16'hA000 + 16'(i), 2'b11);
    for (int i = 0; i < 4; i++) rd({9'd3, 9'(i)}, 2'b11, "R6 page data");
    chk(n_act - a0 == 1, "R6 single activation for same row", n_act - a0, 1);

    // R2 / R7: corner addresses, row change
    a0 = n_act;
    wr({9'h1FF, 9'h000}, 16'h5AA5, 2'b11);
    wr({9'h000, 9'h1FF}, 16'hC33C, 2'b11);
    rd({9'h1FF, 9'h000}, 2'b11, "R2 row 511 col 0");
    rd({9'h000, 9'h1FF}, 2'b11, "R2 row 0 col 511");
    chk(n_act - a0 == 4, "R7 row change reactivates", n_act - a0, 4);

    // R3: byte lanes
    wr({9'd9, 9'd5}, 16'h1234, 2'b11);
    wr({9'd9, 9'd5}, 16'hFFAB, 2'b01);
    rd({9'd9, 9'd5}, 2'b11, "R3 low byte write keeps high byte");
    wr({9'd9, 9'd5}, 16'hCD00, 2'b10);
    rd({9'd9, 9'd5}, 2'b11, "R3 high byte write keeps low byte");
    rd({9'd9, 9'd5}, 2'b10, "R3 high byte read");

    // R9 / R10: idle long enough for refresh with a page open
    a0 = n_ref;
    repeat (E_REFI + 50) @(negedge clk);
    chk(n_ref - a0 >= 1, "R9 refresh during idle", n_ref - a0, 1);
    rd({9'd9, 9'd5}, 2'b11, "R10 data after refresh");

    // R11: long same-row stream
    for (int i = 0; i < 260; i++) wr({9'd7, 9'(i % 16)}, 16'(i * 7), 2'b11);
    for (int i = 0; i < 16; i++) rd({9'd7, 9'(i)}, 2'b11, "R11 stream data");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a;
      logic [1:0] be;
      a = {9'(5 + $urandom % 3), 9'($urandom % 16)};
      be = 2'($urandom % 3 + 1);
      if ($urandom % 2 == 1) wr(a, 16'($urandom), be);
      else rd(a, be, "R2 R3 random read");
    end
    chk(n_ref >= cyc / E_REFI - 1, "R9 refresh count", n_ref, cyc / E_REFI - 1);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule